// File: doc/BRIEF.md
# Phase-Detector Lock Judge

This block decides whether a synthesizer loop is locked. An upstream time-to-digital stage measures, once per phase-detector cycle, how far apart the up and down pulses of the phase detector start. It delivers that skew as an unsigned count of 1 ns units on a valid/ready stream. The block counts how many samples in a row fall inside a tight window. When the count reaches a mode-dependent target, it raises the lock flag.

Once lock is up, the flag drops only when a sample exceeds a looser window. This gives hysteresis between acquiring lock and losing it. Three control bits select the windows and the target count:
- The integer/fractional bit sets the target: 5 samples in integer mode, 40 in fractional mode.
- The fast bit should be set when the phase-detector rate is above 32 MHz.
- The precision bit narrows the tight window, but only when the fast bit is clear.

A counter-reset input clears the flag and the run count. While that input is high, the stream is back-pressured (ready low) and no sample is taken. At all other times the stream is always ready, so an upstream stage never has to hold a sample for more than one cycle. A sample is consumed in exactly the cycle where valid and ready are both high.

Top module: `lock_judge`

## Requirements
- R1: After reset (rst_n low), `locked` is 0 and `skew_ready` is 1.
- R2: With `mode_int` = 0, `locked` rises only after 40 consecutive accepted tight samples; 39 are not enough.
- R3: With `mode_int` = 1, `locked` rises after 5 consecutive accepted tight samples; 4 are not enough.
- R4: A sample is tight when its skew satisfies a limit set by the mode bits:
  - `mode_fast` = 0 and `mode_tight` = 0: skew ≤ 10.
  - `mode_fast` = 0 and `mode_tight` = 1: skew ≤ 6.
  - `mode_fast` = 1: skew ≤ 4, whatever the value of `mode_tight`.
- R5: While locked, an accepted sample whose skew is greater than 15 (`mode_fast` = 0) or greater than 4 (`mode_fast` = 1) clears `locked` at the edge that accepts it. The run count then restarts from zero.
- R6: While locked, accepted samples with skew at or below the unlock limit keep `locked` at 1, including samples that lie between the tight limit and the unlock limit.
- R7: While unlocked, an accepted sample that is not tight resets the run count to zero.
- R8: `cnt_rst` = 1 clears `locked` and the run count at the next edge. While `cnt_rst` is 1, `skew_ready` is 0 and offered samples are ignored.
- R9: Cycles with `skew_valid` = 0 change neither `locked` nor the run count, so a run of tight samples may have gaps.
- R10: `locked` rises at the same clock edge that accepts the final tight sample of the run, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Synchronous clear of lock flag and run count; stalls the stream |
| mode_int | input | 1 | 1 = integer mode (short run), 0 = fractional mode (long run) |
| mode_fast | input | 1 | 1 = phase-detector rate above 32 MHz (narrow windows) |
| mode_tight | input | 1 | 1 = narrower tight window when mode_fast is 0 |
| skew_valid | input | 1 | Skew sample present |
| skew_ready | output | 1 | Block accepts a sample this cycle |
| skew_ns | input | SKEW_W | Up/down edge skew in 1 ns units |
| locked | output | 1 | Lock flag |

## Verification
Unbroken runs of tight samples are sent that stop one short of the target and then reach it. This separates the 5-sample target from the 40-sample target and pins the edge at which the flag rises. Each run is then broken by one loose sample near its end, which shows that the count restarts rather than pauses.

With lock held, skews are placed at the tight limit, inside the hysteresis band, at the unlock limit and one unit above it. This separates the set threshold from the unset threshold in every window setting, and shows that the precision bit has no effect in fast mode. Runs interleaved with idle cycles, and samples offered while the counter reset is held, show that gaps are harmless and that stalled samples leave no trace.

// File: rtl/lj_pkg.sv
package lj_pkg;
  typedef enum logic [1:0] {
    WIN_WIDE   = 2'd0,
    WIN_NARROW = 2'd1,
    WIN_FAST   = 2'd2
  } lj_window_e;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_CLEAR = 2'd2
  } lj_cnt_act_e;
endpackage

// File: rtl/lj_thresholds.sv
module lj_thresholds #(
  parameter int SKEW_W      = 8,
  parameter int CNT_W       = 6,
  parameter int RUN_FRAC    = 40,
  parameter int RUN_INT     = 5,
  parameter int SET_WIDE    = 10,
  parameter int SET_NARROW  = 6,
  parameter int SET_FAST    = 4,
  parameter int UNSET_SLOW  = 15,
  parameter int UNSET_FAST  = 4
) (
  input  logic              mode_int,
  input  logic              mode_fast,
  input  logic              mode_tight,
  output logic [SKEW_W-1:0] set_lim,
  output logic [SKEW_W-1:0] unset_lim,
  output logic [CNT_W-1:0]  run_need
);
  import lj_pkg::*;

  lj_window_e win;

  always_comb begin
    if (mode_fast)       win = WIN_FAST;
    else if (mode_tight) win = WIN_NARROW;
    else                 win = WIN_WIDE;
  end

  always_comb begin
    unique case (win)
      WIN_FAST:   set_lim = SKEW_W'(SET_FAST);
      WIN_NARROW: set_lim = SKEW_W'(SET_NARROW);
      default:    set_lim = SKEW_W'(SET_WIDE);
    endcase
    unset_lim = (win == WIN_FAST) ? SKEW_W'(UNSET_FAST) : SKEW_W'(UNSET_SLOW);
    run_need  = mode_int ? CNT_W'(RUN_INT) : CNT_W'(RUN_FRAC);
  end
endmodule

// File: rtl/lj_run_counter.sv
module lj_run_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lj_pkg::lj_cnt_act_e act,
  input  logic [CNT_W-1:0] run_need,
  output logic             last_hit
);
  import lj_pkg::*;

  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   run_plus;

  assign run_plus = {1'b0, run_q} + (CNT_W+1)'(1);
  assign last_hit = run_plus >= {1'b0, run_need};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      unique case (act)
        ACT_COUNT: run_q <= run_plus[CNT_W-1:0];
        ACT_CLEAR: run_q <= '0;
        default:   run_q <= run_q;
      endcase
    end
  end
endmodule

// File: rtl/lj_lock_fsm.sv
module lj_lock_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_rst,
  input  logic take,
  input  logic is_tight,
  input  logic is_loose,
  input  logic last_hit,
  output lj_pkg::lj_cnt_act_e act,
  output logic locked
);
  import lj_pkg::*;

  logic lock_nx;

  always_comb begin
    lock_nx = locked;
    act     = ACT_HOLD;
    if (cnt_rst) begin
      lock_nx = 1'b0;
      act     = ACT_CLEAR;
    end else if (take) begin
      if (locked) begin
        if (is_loose) begin
          lock_nx = 1'b0;
          act     = ACT_CLEAR;
        end
      end else if (is_tight) begin
        if (last_hit) begin
          lock_nx = 1'b1;
          act     = ACT_CLEAR;
        end else begin
          act     = ACT_COUNT;
        end
      end else begin
        act = ACT_CLEAR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= 1'b0;
    else        locked <= lock_nx;
  end
endmodule

// File: rtl/lock_judge.sv
module lock_judge #(
  parameter int SKEW_W     = 8,
  parameter int RUN_FRAC   = 40,
  parameter int RUN_INT    = 5,
  parameter int SET_WIDE   = 10,
  parameter int SET_NARROW = 6,
  parameter int SET_FAST   = 4,
  parameter int UNSET_SLOW = 15,
  parameter int UNSET_FAST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_rst,
  input  logic              mode_int,
  input  logic              mode_fast,
  input  logic              mode_tight,
  input  logic              skew_valid,
  output logic              skew_ready,
  input  logic [SKEW_W-1:0] skew_ns,
  output logic              locked
);
  import lj_pkg::*;

  localparam int RUN_MAX = (RUN_FRAC > RUN_INT) ? RUN_FRAC : RUN_INT;
  localparam int CNT_W   = $clog2(RUN_MAX + 1);

  logic [SKEW_W-1:0] set_lim, unset_lim;
  logic [CNT_W-1:0]  run_need;
  logic              take, is_tight, is_loose, last_hit;
  lj_cnt_act_e       act;

  assign skew_ready = !cnt_rst;
  assign take       = skew_valid && skew_ready;
  assign is_tight   = skew_ns <= set_lim;
  assign is_loose   = skew_ns > unset_lim;

  lj_thresholds #(
    .SKEW_W(SKEW_W), .CNT_W(CNT_W), .RUN_FRAC(RUN_FRAC), .RUN_INT(RUN_INT),
    .SET_WIDE(SET_WIDE), .SET_NARROW(SET_NARROW), .SET_FAST(SET_FAST),
    .UNSET_SLOW(UNSET_SLOW), .UNSET_FAST(UNSET_FAST)
  ) u_thr (
    .mode_int(mode_int), .mode_fast(mode_fast), .mode_tight(mode_tight),
    .set_lim(set_lim), .unset_lim(unset_lim), .run_need(run_need)
  );

  lj_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .act(act), .run_need(run_need), .last_hit(last_hit)
  );

  lj_lock_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .take(take),
    .is_tight(is_tight), .is_loose(is_loose), .last_hit(last_hit),
    .act(act), .locked(locked)
  );
endmodule

// File: rtl/lock_judge_chk.sv
module lock_judge_chk #(
  parameter int SKEW_W     = 8,
  parameter int RUN_FRAC   = 40,
  parameter int RUN_INT    = 5,
  parameter int SET_WIDE   = 10,
  parameter int SET_NARROW = 6,
  parameter int SET_FAST   = 4,
  parameter int UNSET_SLOW = 15,
  parameter int UNSET_FAST = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_rst,
  input logic              mode_int,
  input logic              mode_fast,
  input logic              mode_tight,
  input logic              skew_valid,
  input logic              skew_ready,
  input logic [SKEW_W-1:0] skew_ns,
  input logic              locked
);
  logic        acc, ok_set, bad_unset;
  int unsigned need_c, set_c, unset_c;
  logic [15:0] run_c;

  always_comb begin
    set_c     = mode_fast ? SET_FAST : (mode_tight ? SET_NARROW : SET_WIDE);
    unset_c   = mode_fast ? UNSET_FAST : UNSET_SLOW;
    need_c    = mode_int ? RUN_INT : RUN_FRAC;
    acc       = skew_valid && skew_ready;
    ok_set    = 32'(skew_ns) <= set_c;
    bad_unset = 32'(skew_ns) > unset_c;
  end

  // Independent tally of consecutive tight samples taken while unlocked.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_c <= '0;
    else if (cnt_rst)             run_c <= '0;
    else if (acc && locked)       run_c <= '0;
    else if (acc && !ok_set)      run_c <= '0;
    else if (acc && run_c != '1)  run_c <= run_c + 16'd1;
  end

  a_r8_clear_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> !locked);

  a_r5_unlock_loose: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && acc && bad_unset) |=> !locked);

  a_r6_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && acc && !bad_unset) |=> locked);

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!skew_valid && !cnt_rst) |=> $stable(locked));

  a_r4_rise_on_tight: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(acc && ok_set));

  // R3 shares this property: the target depends on mode_int.
  a_r2_min_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && acc && ok_set && (32'(run_c) + 1 < need_c)) |=> !locked);

  a_r10_rise_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && acc && ok_set && (32'(run_c) + 1 == need_c)) |=> locked);
endmodule

bind lock_judge lock_judge_chk #(
  .SKEW_W(SKEW_W), .RUN_FRAC(RUN_FRAC), .RUN_INT(RUN_INT),
  .SET_WIDE(SET_WIDE), .SET_NARROW(SET_NARROW), .SET_FAST(SET_FAST),
  .UNSET_SLOW(UNSET_SLOW), .UNSET_FAST(UNSET_FAST)
) u_lock_judge_chk (
  .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .mode_int(mode_int),
  .mode_fast(mode_fast), .mode_tight(mode_tight), .skew_valid(skew_valid),
  .skew_ready(skew_ready), .skew_ns(skew_ns), .locked(locked)
);

// File: tb/test_lock_judge.sv
module test_lock_judge;
  localparam int CLK_HALF = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_rst = 1'b0;
  logic       mode_int = 1'b0, mode_fast = 1'b0, mode_tight = 1'b0;
  logic       skew_valid = 1'b0;
  logic       skew_ready;
  logic [7:0] skew_ns = '0;
  logic       locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  lock_judge i_lock_judge (
    .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .mode_int(mode_int),
    .mode_fast(mode_fast), .mode_tight(mode_tight), .skew_valid(skew_valid),
    .skew_ready(skew_ready), .skew_ns(skew_ns), .locked(locked)
  );

  always #(CLK_HALF) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Offer one sample at a negedge; on return the accepting edge has passed.
  task automatic send(input int s);
    skew_valid = 1'b1;
    skew_ns    = 8'(s);
    @(negedge clk);
    skew_valid = 1'b0;
  endtask

  task automatic send_n(input int n, input int s);
    for (int i = 0; i < n; i++) send(s);
  endtask

  task automatic clear_all();
    cnt_rst = 1'b1;
    @(negedge clk);
    cnt_rst = 1'b0;
  endtask

  task automatic set_mode(input logic i, input logic f, input logic t);
    mode_int = i; mode_fast = f; mode_tight = t;
  endtask

  task automatic t_reset();
    chk("R1 locked after reset", locked, 1'b0);
    chk("R1 ready after reset", skew_ready, 1'b1);
  endtask

  task automatic t_frac_run();
    clear_all();
    set_mode(1'b0, 1'b0, 1'b0);
    send_n(39, 10);
    chk("R2 39 tight samples not enough", locked, 1'b0);
    send(10);
    chk("R2/R10 40th tight sample locks", locked, 1'b1);
  endtask

  task automatic t_hysteresis_slow();
    // continues locked from t_frac_run
    send(11);
    chk("R6 skew 11 inside band keeps lock", locked, 1'b1);
    send(15);
    chk("R6 skew 15 at unlock limit keeps lock", locked, 1'b1);
    send(16);
    chk("R5 skew 16 unlocks", locked, 1'b0);
    send_n(39, 0);
    chk("R5 count restarted after unlock", locked, 1'b0);
    send(0);
    chk("R2 relock after full run", locked, 1'b1);
  endtask

  task automatic t_restart();
    clear_all();
    set_mode(1'b0, 1'b0, 1'b0);
    send_n(38, 3);
    send(11);
    chk("R7 loose sample while unlocked", locked, 1'b0);
    send_n(39, 3);
    chk("R7 run restarted from zero", locked, 1'b0);
    send(3);
    chk("R7 lock after fresh full run", locked, 1'b1);
  endtask

  task automatic t_int_narrow();
    clear_all();
    set_mode(1'b1, 1'b0, 1'b1);
    send_n(4, 6);
    send(7);
    chk("R4 skew 7 above narrow limit", locked, 1'b0);
    send_n(4, 6);
    chk("R3 4 tight samples not enough", locked, 1'b0);
    send(6);
    chk("R3 5th tight sample locks", locked, 1'b1);
  endtask

  task automatic t_fast();
    clear_all();
    set_mode(1'b1, 1'b1, 1'b1);
    send_n(4, 4);
    send(5);
    chk("R4 fast skew 5 not tight, ldp ignored", locked, 1'b0);
    send_n(5, 4);
    chk("R4 fast skew 4 tight, ldp ignored", locked, 1'b1);
    send(4);
    chk("R6 fast skew 4 keeps lock", locked, 1'b1);
    send(5);
    chk("R5 fast skew 5 unlocks", locked, 1'b0);
    mode_tight = 1'b0;
    send_n(4, 4);
    chk("R4 fast ldp=0 run of 4", locked, 1'b0);
    send(4);
    chk("R4 fast ldp=0 locks at 5", locked, 1'b1);
  endtask

  task automatic t_gaps();
    clear_all();
    set_mode(1'b1, 1'b0, 1'b0);
    send_n(3, 10);
    skew_ns = 8'd200;
    repeat (6) @(negedge clk);
    chk("R9 idle cycles keep unlocked", locked, 1'b0);
    send(10);
    chk("R9 4th tight after gap", locked, 1'b0);
    send(10);
    chk("R9 run survives gap and locks", locked, 1'b1);
    skew_ns = 8'd255;
    repeat (5) @(negedge clk);
    chk("R9 idle cycles keep lock", locked, 1'b1);
  endtask

  task automatic t_cnt_rst();
    // locked in integer mode from t_gaps
    cnt_rst    = 1'b1;
    skew_valid = 1'b1;
    skew_ns    = 8'd0;
    #1;
    chk("R8 ready low during counter reset", skew_ready, 1'b0);
    @(negedge clk);
    chk("R8 counter reset clears lock", locked, 1'b0);
    repeat (9) @(negedge clk);
    chk("R8 samples ignored during counter reset", locked, 1'b0);
    cnt_rst    = 1'b0;
    skew_valid = 1'b0;
    send_n(4, 0);
    chk("R8 count cleared, 4 not enough", locked, 1'b0);
    send(0);
    chk("R8 lock after full run post reset", locked, 1'b1);
    // partial run then clear: count must restart
    clear_all();
    send_n(3, 0);
    clear_all();
    send_n(4, 0);
    chk("R8 partial run discarded by counter reset", locked, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frac_run();
    t_hysteresis_slow();
    t_restart();
    t_int_narrow();
    t_fast();
    t_gaps();
    t_cnt_rst();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(2 * CLK_HALF * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule